// File: doc/BRIEF.md
# Remote Signaling Link Pulse Scheduler

This block sits beside a twisted-pair link-integrity function and decides when each outgoing link pulse leaves. It also carries local status to the far end by stretching or shortening the gap before each pulse. With nothing to report it emits pulses at a fixed standard gap of 16 ms. A local link-down, jabber or compatibility request replaces that gap with a repeating pattern built from 10, 15 and 20 ms gaps. All timing is counted in ticks of a one-millisecond strobe supplied by the surrounding logic. Pulses are held back while the transmitter is busy.

In the other direction the block measures the gap between successive received link pulses. It rounds each gap to one of the three gap lengths, or to "none" when the gap lies outside all of them. A tracker for each pattern watches the run of gap-to-gap steps. When a run is long enough it raises the matching remote-status flag, and it drops the flag again after repeated mismatches. Pulse waveform shaping and link-fail handling belong to neighbouring blocks.

Top module: `rsig_link_sched`

## Requirements
- R1: Reset forces the pulse output and all three remote flags low. After reset the first gap is the standard gap of 16 ticks, and with no request active every gap stays 16 ticks.
- R2: With link-down requested (and jabber not requested), the gaps run 10, 15, 20 ticks and then repeat from 10.
- R3: With jabber requested, the gaps run 20, 15, 10 ticks and then repeat from 20.
- R4: With only compatibility requested, the gaps alternate 10, 20, 10, 20 ticks.
- R5: When several requests are active together, jabber wins over link-down and link-down wins over compatibility.
- R6: A change of the winning request takes effect only at the next emitted pulse. The gap already in progress keeps its length, and the following gap is the first gap of the new pattern.
- R7: A pulse is emitted only while the transmit-idle input is high. A pulse that falls due while transmit is busy is sent one clock after idle returns. The pulse output is high for exactly one clock, one clock after the tick that completes the gap, and each emitted pulse restarts the gap count.
- R8: A received gap is the number of ticks between two received pulses. A gap of 8 to 12 ticks counts as short, 13 to 17 as medium and 18 to 22 as long. Any other gap, and the interval ending at the first pulse after reset, matches no pattern step.
- R9: The remote link-down flag rises after three consecutive received steps short→medium, medium→long or long→short, so four gaps such as 10, 15, 20, 10 are enough.
- R10: The remote jabber flag rises after three consecutive received steps long→medium, medium→short or short→long.
- R11: The remote compatibility flag rises after two consecutive received steps short→long or long→short.
- R12: A raised remote flag falls after two consecutive received gaps that are not valid steps of its pattern. A single mismatched gap followed by a valid step leaves the flag up.
- R13: Remote flags change only in the clock after a received pulse. Remote link-down and remote jabber are never high together. A standard 16-tick pulse train raises no flag, and a link-down train does not raise the compatibility flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick_i | input | 1 | One-clock strobe per millisecond |
| loc_link_down_i | input | 1 | Request to signal local link down |
| loc_jabber_i | input | 1 | Request to signal local jabber |
| loc_compat_i | input | 1 | Request to signal compatibility |
| tx_idle_i | input | 1 | High while the transmitter is idle |
| rx_pulse_i | input | 1 | One-clock strobe per received link pulse |
| lp_pulse_o | output | 1 | One-clock strobe: emit a link pulse now |
| rem_link_down_o | output | 1 | Far end signals link down |
| rem_jabber_o | output | 1 | Far end signals jabber |
| rem_compat_o | output | 1 | Far end signals compatibility |

## Verification
The bench changes the request in the middle of a gap. A design that reloaded the pattern at once would cut the gap in progress short, and one that kept its old position would start the new pattern part-way through. It tries received gaps of 7, 8, 12, 13, 22 and 23 ticks, so a tolerance window that is one tick too wide or too narrow shows up as a flag that rises or stays low when it should not. It checks that a single stray gap does not drop a remote flag while two in a row do, which catches a mismatch counter that does not reset. It also feeds a link-down train and watches the compatibility flag, since the long→short step belongs to both patterns and a tracker that accepts isolated steps would raise both flags. Holding transmit busy past the due point checks that no pulse escapes and that the held pulse follows idle by exactly one clock.

// File: rtl/rsig_pkg.sv
package rsig_pkg;

  // Transmit signaling pattern; the same codes name the receive trackers.
  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_LDN = 2'd1,
    MODE_JAB = 2'd2,
    MODE_CMP = 2'd3
  } tx_mode_e;

  // Received gap rounded to a nominal length.
  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_SHRT = 2'd1,
    GAP_MED  = 2'd2,
    GAP_LONG = 2'd3
  } gap_cls_e;

  // True when cur may follow prv inside pattern pat.
  function automatic logic step_ok(tx_mode_e pat, gap_cls_e prv, gap_cls_e cur);
    logic r;
    case (pat)
      MODE_LDN: r = (prv == GAP_SHRT && cur == GAP_MED)  ||
                    (prv == GAP_MED  && cur == GAP_LONG) ||
                    (prv == GAP_LONG && cur == GAP_SHRT);
      MODE_JAB: r = (prv == GAP_LONG && cur == GAP_MED)  ||
                    (prv == GAP_MED  && cur == GAP_SHRT) ||
                    (prv == GAP_SHRT && cur == GAP_LONG);
      MODE_CMP: r = (prv == GAP_SHRT && cur == GAP_LONG) ||
                    (prv == GAP_LONG && cur == GAP_SHRT);
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Number of gaps in one period of a pattern.
  function automatic int pat_len(tx_mode_e pat);
    int n;
    case (pat)
      MODE_LDN, MODE_JAB: n = 3;
      MODE_CMP:           n = 2;
      default:            n = 1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rsig_tx_sched.sv
module rsig_tx_sched
  import rsig_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int GAP_S   = 10,
  parameter int GAP_M   = 15,
  parameter int GAP_L   = 20,
  parameter int GAP_STD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick_i,
  input  logic req_ldn_i,
  input  logic req_jab_i,
  input  logic req_cmp_i,
  input  logic tx_idle_i,
  output logic pulse_o
);

  localparam logic [CNT_W-1:0] T_S     = CNT_W'(GAP_S);
  localparam logic [CNT_W-1:0] T_M     = CNT_W'(GAP_M);
  localparam logic [CNT_W-1:0] T_L     = CNT_W'(GAP_L);
  localparam logic [CNT_W-1:0] T_STD   = CNT_W'(GAP_STD);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tx_mode_e         want;
  tx_mode_e         cur;
  logic [1:0]       idx;
  logic [1:0]       idx_last;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             fire;

  // Fixed priority: jabber, then link down, then compatibility.
  always_comb begin
    if (req_jab_i)      want = MODE_JAB;
    else if (req_ldn_i) want = MODE_LDN;
    else if (req_cmp_i) want = MODE_CMP;
    else                want = MODE_STD;
  end

  // Gap length for the current position in the current pattern.
  always_comb begin
    case (cur)
      MODE_LDN: target = (idx == 2'd0) ? T_S : (idx == 2'd1) ? T_M : T_L;
      MODE_JAB: target = (idx == 2'd0) ? T_L : (idx == 2'd1) ? T_M : T_S;
      MODE_CMP: target = idx[0] ? T_L : T_S;
      default:  target = T_STD;
    endcase
  end

  always_comb begin
    case (cur)
      MODE_LDN, MODE_JAB: idx_last = 2'd2;
      MODE_CMP:           idx_last = 2'd1;
      default:            idx_last = 2'd0;
    endcase
  end

  assign fire = (cnt >= target) && tx_idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= MODE_STD;
      idx     <= 2'd0;
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
      if (fire) begin
        cnt <= ms_tick_i ? CNT_W'(1) : '0;
        if (want != cur) begin
          cur <= want;
          idx <= 2'd0;
        end else begin
          idx <= (idx == idx_last) ? 2'd0 : idx + 2'd1;
        end
      end else if (ms_tick_i && cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rsig_rx_gap.sv
module rsig_rx_gap
  import rsig_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int GAP_S = 10,
  parameter int GAP_M = 15,
  parameter int GAP_L = 20,
  parameter int TOL   = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ms_tick_i,
  input  logic     rx_pulse_i,
  output logic     gap_evt_o,
  output gap_cls_e prv_cls_o,
  output gap_cls_e cur_cls_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             seen;

  function automatic logic near(int g, int c);
    return (g + TOL >= c) && (g <= c + TOL);
  endfunction

  always_comb begin
    if (near(int'(cnt), GAP_S))      cur_cls_o = GAP_SHRT;
    else if (near(int'(cnt), GAP_M)) cur_cls_o = GAP_MED;
    else if (near(int'(cnt), GAP_L)) cur_cls_o = GAP_LONG;
    else                             cur_cls_o = GAP_NONE;
  end

  // A gap exists only once a first pulse has opened it.
  assign gap_evt_o = rx_pulse_i && seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      seen      <= 1'b0;
      prv_cls_o <= GAP_NONE;
    end else if (rx_pulse_i) begin
      cnt       <= ms_tick_i ? CNT_W'(1) : '0;
      seen      <= 1'b1;
      prv_cls_o <= seen ? cur_cls_o : GAP_NONE;
    end else if (ms_tick_i && cnt != CNT_MAX) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rsig_pat_track.sv
module rsig_pat_track
  import rsig_pkg::*;
#(
  parameter tx_mode_e PAT        = MODE_LDN,
  parameter int       CLR_MISSES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     step_i,
  input  gap_cls_e prv_i,
  input  gap_cls_e cur_i,
  output logic     flag_o
);

  localparam int LEN = pat_len(PAT);
  localparam int RW  = $clog2(LEN + 1);
  localparam int MW  = $clog2(CLR_MISSES + 1);

  logic [RW-1:0] run;
  logic [MW-1:0] miss;
  logic          ok;

  assign ok = step_ok(PAT, prv_i, cur_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      miss   <= '0;
      flag_o <= 1'b0;
    end else if (step_i) begin
      if (ok) begin
        miss <= '0;
        if (int'(run) < LEN)      run    <= run + RW'(1);
        if (int'(run) + 1 >= LEN) flag_o <= 1'b1;
      end else begin
        run <= '0;
        if (int'(miss) < CLR_MISSES)      miss   <= miss + MW'(1);
        if (int'(miss) + 1 >= CLR_MISSES) flag_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rsig_link_sched.sv
module rsig_link_sched
  import rsig_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int GAP_S      = 10,
  parameter int GAP_M      = 15,
  parameter int GAP_L      = 20,
  parameter int GAP_STD    = 16,
  parameter int TOL        = 2,
  parameter int CLR_MISSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick_i,
  input  logic loc_link_down_i,
  input  logic loc_jabber_i,
  input  logic loc_compat_i,
  input  logic tx_idle_i,
  input  logic rx_pulse_i,
  output logic lp_pulse_o,
  output logic rem_link_down_o,
  output logic rem_jabber_o,
  output logic rem_compat_o
);

  localparam int NPAT = 3;

  logic            gap_evt;
  gap_cls_e        prv_cls;
  gap_cls_e        cur_cls;
  logic [NPAT-1:0] rem_flags;

  rsig_tx_sched #(
    .CNT_W(CNT_W), .GAP_S(GAP_S), .GAP_M(GAP_M), .GAP_L(GAP_L), .GAP_STD(GAP_STD)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .ms_tick_i (ms_tick_i),
    .req_ldn_i (loc_link_down_i),
    .req_jab_i (loc_jabber_i),
    .req_cmp_i (loc_compat_i),
    .tx_idle_i (tx_idle_i),
    .pulse_o   (lp_pulse_o)
  );

  rsig_rx_gap #(
    .CNT_W(CNT_W), .GAP_S(GAP_S), .GAP_M(GAP_M), .GAP_L(GAP_L), .TOL(TOL)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .ms_tick_i  (ms_tick_i),
    .rx_pulse_i (rx_pulse_i),
    .gap_evt_o  (gap_evt),
    .prv_cls_o  (prv_cls),
    .cur_cls_o  (cur_cls)
  );

  for (genvar k = 0; k < NPAT; k++) begin : g_trk
    localparam tx_mode_e PK = (k == 0) ? MODE_LDN : (k == 1) ? MODE_JAB : MODE_CMP;
    rsig_pat_track #(
      .PAT(PK), .CLR_MISSES(CLR_MISSES)
    ) u_trk (
      .clk    (clk),
      .rst    (rst),
      .step_i (gap_evt),
      .prv_i  (prv_cls),
      .cur_i  (cur_cls),
      .flag_o (rem_flags[k])
    );
  end

  assign rem_link_down_o = rem_flags[0];
  assign rem_jabber_o    = rem_flags[1];
  assign rem_compat_o    = rem_flags[2];

endmodule

// File: rtl/rsig_link_sched_chk.sv
module rsig_link_sched_chk #(
  parameter int CNT_W = 5,
  parameter int GAP_S = 10
) (
  input logic clk,
  input logic rst,
  input logic ms_tick_i,
  input logic tx_idle_i,
  input logic rx_pulse_i,
  input logic lp_pulse_o,
  input logic rem_link_down_o,
  input logic rem_jabber_o,
  input logic rem_compat_o
);

  logic [CNT_W-1:0] tcnt;

  // Ticks seen since the last emitted pulse, counted independently of the design.
  always_ff @(posedge clk) begin
    if (rst)                                 tcnt <= '0;
    else if (lp_pulse_o)                     tcnt <= ms_tick_i ? CNT_W'(1) : '0;
    else if (ms_tick_i && tcnt != '1)        tcnt <= tcnt + CNT_W'(1);
  end

  // R7
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    lp_pulse_o |-> $past(tx_idle_i));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    lp_pulse_o |=> !lp_pulse_o);

  // R2
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    lp_pulse_o |-> (int'(tcnt) >= GAP_S - 1));

  // R13
  rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_pulse_i |=> $stable({rem_link_down_o, rem_jabber_o, rem_compat_o}));

  // R13
  ldn_jab_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rem_link_down_o && rem_jabber_o));

endmodule

bind rsig_link_sched rsig_link_sched_chk #(
  .CNT_W(CNT_W), .GAP_S(GAP_S)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .ms_tick_i       (ms_tick_i),
  .tx_idle_i       (tx_idle_i),
  .rx_pulse_i      (rx_pulse_i),
  .lp_pulse_o      (lp_pulse_o),
  .rem_link_down_o (rem_link_down_o),
  .rem_jabber_o    (rem_jabber_o),
  .rem_compat_o    (rem_compat_o)
);

// File: tb/rsig_link_sched_tb.sv
`timescale 1ns/1ps
module rsig_link_sched_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic ldn = 1'b0, jab = 1'b0, cmp = 1'b0;
  logic idle = 1'b1;
  logic rxp = 1'b0;
  logic pulse, r_ldn, r_jab, r_cmp;

  int checks = 0;
  int errors = 0;
  int sw_at = 0;
  logic [2:0] sw_req = 3'b000;

  always #2 clk = ~clk;

  rsig_link_sched u_dut (
    .clk             (clk),
    .rst             (rst),
    .ms_tick_i       (ms_tick),
    .loc_link_down_i (ldn),
    .loc_jabber_i    (jab),
    .loc_compat_i    (cmp),
    .tx_idle_i       (idle),
    .rx_pulse_i      (rxp),
    .lp_pulse_o      (pulse),
    .rem_link_down_o (r_ldn),
    .rem_jabber_o    (r_jab),
    .rem_compat_o    (r_cmp)
  );

  // {req[2]=jabber, req[1]=link down, req[0]=compat, gap0, gap1, gap2, gap3}
  localparam int VN = 7;
  localparam logic [22:0] VEC [VN] = '{
    {3'b000, 5'd16, 5'd16, 5'd16, 5'd16},
    {3'b010, 5'd10, 5'd15, 5'd20, 5'd10},
    {3'b100, 5'd20, 5'd15, 5'd10, 5'd20},
    {3'b001, 5'd10, 5'd20, 5'd10, 5'd20},
    {3'b110, 5'd20, 5'd15, 5'd10, 5'd20},
    {3'b011, 5'd10, 5'd15, 5'd20, 5'd10},
    {3'b111, 5'd20, 5'd15, 5'd10, 5'd20}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_req(logic [2:0] r);
    jab = r[2];
    ldn = r[1];
    cmp = r[0];
  endtask

  task automatic tick_once(output logic hit);
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    hit = 1'b0;
    @(negedge clk) if (pulse) hit = 1'b1;
    @(negedge clk) if (pulse) hit = 1'b1;
  endtask

  task automatic next_gap(output int gap);
    logic h;
    gap = 0;
    h = 1'b0;
    while (!h && gap < 40) begin
      gap++;
      if (sw_at != 0 && gap == sw_at) set_req(sw_req);
      tick_once(h);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rx_fire();
    @(negedge clk) rxp = 1'b1;
    @(negedge clk) rxp = 1'b0;
  endtask

  task automatic rx_gap(int n);
    logic h;
    repeat (n) tick_once(h);
    rx_fire();
  endtask

  function automatic string vtag(int v);
    case (v)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    int g;
    int seen;
    logic h;
    logic [22:0] e;

    repeat (4) @(negedge clk);
    chk("R1 pulse in reset", int'(pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pulse after reset", int'(pulse), 0);
    chk("R1 flags after reset", int'({r_ldn, r_jab, r_cmp}), 0);
    next_gap(g);
    chk("R1 first gap", g, 16);

    // Table walk: each vector sets requests, passes one boundary, then checks four gaps.
    for (int v = 0; v < VN; v++) begin
      e = VEC[v];
      set_req(e[22:20]);
      next_gap(g);
      for (int j = 0; j < 4; j++) begin
        next_gap(g);
        chk(vtag(v), g, int'(e[19 - 5*j -: 5]));
      end
    end

    // R6: switch to jabber in the middle of a link-down medium gap
    set_req(3'b010);
    next_gap(g);
    next_gap(g);
    chk("R6 first new gap", g, 10);
    sw_at = 3;
    sw_req = 3'b100;
    next_gap(g);
    chk("R6 gap in flight keeps length", g, 15);
    sw_at = 0;
    next_gap(g);
    chk("R6 new pattern starts at first gap", g, 20);
    next_gap(g);
    chk("R6 new pattern second gap", g, 15);

    // R7: transmit busy holds the pulse back
    set_req(3'b000);
    next_gap(g);
    idle = 1'b0;
    seen = 0;
    repeat (20) begin
      tick_once(h);
      if (h) seen = 1;
    end
    chk("R7 no pulse while busy", seen, 0);
    @(negedge clk) idle = 1'b1;
    @(negedge clk) chk("R7 pulse one clock after idle", int'(pulse), 1);
    @(negedge clk) chk("R7 pulse one clock wide", int'(pulse), 0);
    next_gap(g);
    chk("R7 gap restarts after held pulse", g, 16);

    // R9, R12: remote link down
    do_reset();
    rx_fire();
    rx_gap(10); rx_gap(15); rx_gap(20);
    chk("R9 not yet after two steps", int'(r_ldn), 0);
    rx_gap(10);
    chk("R9 link down set", int'(r_ldn), 1);
    chk("R13 jabber stays low", int'(r_jab), 0);
    rx_gap(20);
    chk("R12 one miss keeps flag", int'(r_ldn), 1);
    rx_gap(10);
    chk("R12 valid step after miss", int'(r_ldn), 1);
    rx_gap(10);
    chk("R12 first of two misses", int'(r_ldn), 1);
    rx_gap(10);
    chk("R12 two misses clear", int'(r_ldn), 0);

    // R10, R8: remote jabber using tolerance edges 22, 13, 12, 18
    do_reset();
    rx_fire();
    rx_gap(22); rx_gap(13); rx_gap(12);
    chk("R10 not yet", int'(r_jab), 0);
    rx_gap(18);
    chk("R10 jabber set", int'(r_jab), 1);
    chk("R13 link down stays low", int'(r_ldn), 0);

    // R11, R8: compatibility with short edge 8
    do_reset();
    rx_fire();
    rx_gap(8); rx_gap(20);
    chk("R11 not yet", int'(r_cmp), 0);
    rx_gap(10);
    chk("R11 compat set", int'(r_cmp), 1);

    // R8: 23 is out of range
    do_reset();
    rx_fire();
    rx_gap(10); rx_gap(15); rx_gap(23); rx_gap(10); rx_gap(15); rx_gap(20);
    chk("R8 gap 23 breaks run", int'(r_ldn), 0);
    do_reset();
    rx_fire();
    rx_gap(10); rx_gap(15); rx_gap(22); rx_gap(10);
    chk("R8 gap 22 accepted", int'(r_ldn), 1);

    // R8: 7 is out of range
    do_reset();
    rx_fire();
    rx_gap(7); rx_gap(15); rx_gap(20); rx_gap(10);
    chk("R8 gap 7 rejected", int'(r_ldn), 0);

    // R13: standard train raises nothing
    do_reset();
    rx_fire();
    repeat (5) rx_gap(16);
    chk("R13 standard train no flag", int'({r_ldn, r_jab, r_cmp}), 0);

    // R13: link-down train does not alias to compat, flag holds without pulses
    do_reset();
    rx_fire();
    rx_gap(10); rx_gap(15); rx_gap(20); rx_gap(10); rx_gap(15); rx_gap(20); rx_gap(10);
    chk("R13 link down set", int'(r_ldn), 1);
    chk("R13 no compat alias", int'(r_cmp), 0);
    repeat (30) tick_once(h);
    chk("R13 flag holds without rx pulse", int'(r_ldn), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule